// File: doc/BRIEF.md
# Warp Issue Gate with Compiler-Directed Dependency Barriers

This block decides, cycle by cycle, which warps may send their next instruction to execution. No hardware compares register numbers to find hazards. The compiler attaches a 21-bit control field to every instruction, and that field is the only hazard information the block uses:

- a stall count that spaces out back-to-back issues from one warp;
- write and read barrier indices that a variable-latency instruction raises when it issues;
- a wait mask that holds a consumer back until the barriers it names have drained;
- a yield hint that tells the scheduler whether to stay on the current warp;
- reuse flags that are passed on unchanged alongside the grant.

Each warp has its own stall counter and six barrier counters. A completion pulse from the execution side lowers a barrier counter. Warps are spread over scheduler partitions by warp index modulo the partition count. Each partition has one dispatcher. Inside a partition, a round-robin pointer picks among the warps that are both requesting and eligible. The grant for a cycle is computed combinationally from the current requests and the registered state. The effects of an issue (the stall load and the barrier increments) are registered at the end of that same cycle.

Top module: `wig_issue_gate`

## Requirements
- R1: Control field bit positions are fixed as follows.
  - [3:0] stall count.
  - [4] yield hint.
  - [7:5] write barrier index.
  - [10:8] read barrier index.
  - [16:11] wait mask, where bit 11+b names barrier b.
  - [20:17] reuse flags.
- R2: After reset, every stall and barrier counter is zero and every round-robin pointer sits on local member 0. When all warps request with a plain control field, each partition grants its lowest-numbered warp.
- R3: Suppose a warp issues in cycle t with stall count S. It is not granted in cycles t+1 to t+S, and it is eligible again in cycle t+S+1. With S=0 it can issue in consecutive cycles.
- R4: On issue, a write or read barrier index of 0 to 5 raises that barrier's counter by one. Index 6 or 7 raises nothing. If both indices name the same barrier, that counter rises by two.
- R5: A warp whose wait mask names barrier b is not granted while its counter b is nonzero. A completion pulse in cycle t lowers the counter at the end of cycle t, so the waiting warp is granted no earlier than t+1.
- R6: Barrier counters saturate at 7, and a completion pulse on a zero counter is dropped. Counters are private to each warp: completion bit w*6+b of `cmpl_mask` affects only warp w, barrier b.
- R7: Warp w belongs to partition w mod 4. Each partition grants at most one warp per cycle, and the partitions arbitrate independently of each other.
- R8: Within a partition, the search starts at the pointer and skips warps that are idle or blocked.
  - If the granted warp's yield hint is clear, the pointer moves onto the granted warp, so that warp keeps priority.
  - If the yield hint is set, the pointer moves to the member after the granted warp.
- R9: `iss_reuse` slice p carries the reuse flags of the instruction granted in partition p that cycle. The slice is zero when partition p grants nothing.
- R10: A warp is never granted unless its request is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_WARPS | Warp w has an instruction ready to issue |
| req_ctl | input | NUM_WARPS*21 | Control field of each warp's pending instruction; warp w at [w*21 +: 21] |
| cmpl_mask | input | NUM_WARPS*6 | Completion pulses; bit w*6+b releases one count of warp w barrier b |
| grant | output | NUM_WARPS | Warp w issues this cycle |
| iss_reuse | output | NUM_PARTS*4 | Reuse flags of the instruction issued in each partition |

## Verification
The bench goes after the exact end of the stall window. A counter that is loaded one cycle late, or treated as S-1, would grant one cycle early or one cycle late. It checks barrier timing at the cycle granularity of R5, and a design that unblocks on the same cycle as the completion pulse fails that check. It fills a barrier past 7 and then drains it, and it pulses an empty barrier. A counter that wraps instead of saturating clears after one pulse, and one that underflows needs seven pulses; both show up as a wrong grant cycle. Round-robin sequences confirm that a yield hands the dispatcher to the partner warp, that a non-yielding warp keeps priority, and that completions addressed to another warp leave a waiter blocked.

// File: rtl/wig_pkg.sv
package wig_pkg;
    localparam int BAR_N   = 6;
    localparam int IDX_W   = 3;
    localparam int STALL_W = 4;
    localparam int REUSE_W = 4;
    localparam int CTRL_W  = REUSE_W + BAR_N + 2 * IDX_W + 1 + STALL_W;

    // Field order from the top bit down; the decode depends on it.
    typedef struct packed {
        logic [REUSE_W-1:0] reuse;
        logic [BAR_N-1:0]   wait_mask;
        logic [IDX_W-1:0]   rd_bar;
        logic [IDX_W-1:0]   wr_bar;
        logic               yield_hint;
        logic [STALL_W-1:0] stall;
    } ctl_t;
endpackage

// File: rtl/wig_warp_ctx.sv
module wig_warp_ctx
    import wig_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_i,
    input  logic [STALL_W-1:0] stall_i,
    input  logic [BAR_N-1:0]   wait_i,
    input  logic [IDX_W-1:0]   rd_i,
    input  logic [IDX_W-1:0]   wr_i,
    input  logic [BAR_N-1:0]   cmpl_i,
    output logic               ready_o
);
    localparam int CMAX = (1 << CNT_W) - 1;

    typedef struct packed {
        logic [STALL_W-1:0]          stall;
        logic [BAR_N-1:0][CNT_W-1:0] cnt;
    } st_t;

    st_t              st_d, st_q;
    logic [BAR_N-1:0] busy;
    int               nxt_c;

    always_comb begin
        st_d  = st_q;
        nxt_c = 0;
        if (st_q.stall != '0) st_d.stall = st_q.stall - STALL_W'(1);
        if (issue_i) st_d.stall = stall_i;
        for (int b = 0; b < BAR_N; b++) begin
            nxt_c = int'(st_q.cnt[b]);
            if (issue_i && wr_i == IDX_W'(b)) nxt_c = nxt_c + 1;
            if (issue_i && rd_i == IDX_W'(b)) nxt_c = nxt_c + 1;
            if (cmpl_i[b] && st_q.cnt[b] != '0) nxt_c = nxt_c - 1;
            if (nxt_c > CMAX) nxt_c = CMAX;
            st_d.cnt[b] = CNT_W'(nxt_c);
        end
    end

    always_comb begin
        for (int b = 0; b < BAR_N; b++) busy[b] = (st_q.cnt[b] != '0);
        ready_o = (st_q.stall == '0) && ((wait_i & busy) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    stall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && stall_i != '0) |=> !issue_i);

    // R5
    wait_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> ((wait_i & busy) == '0));

    for (genvar gb = 0; gb < BAR_N; gb++) begin : g_bar_chk
        // R5
        release_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            int'($past(st_q.cnt[gb])) <= int'(st_q.cnt[gb]) + 1);
        // R6
        no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.cnt[gb] == '0 && !issue_i) |=> st_q.cnt[gb] == '0);
        // R4
        raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_i && wr_i == IDX_W'(gb) && !cmpl_i[gb] && int'(st_q.cnt[gb]) < CMAX)
            |=> int'(st_q.cnt[gb]) > int'($past(st_q.cnt[gb])));
    end
endmodule

// File: rtl/wig_part_arb.sv
module wig_part_arb #(
    parameter int MEMB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [MEMB-1:0] cand_i,
    input  logic [MEMB-1:0] yld_i,
    output logic [MEMB-1:0] gnt_o
);
    localparam int PW = (MEMB > 1) ? $clog2(MEMB) : 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
    } st_t;

    st_t st_d, st_q;
    int  pick_c;
    int  idx_c;

    always_comb begin
        st_d   = st_q;
        gnt_o  = '0;
        pick_c = -1;
        idx_c  = 0;
        for (int k = 0; k < MEMB; k++) begin
            idx_c = (int'(st_q.ptr) + k) % MEMB;
            if (pick_c < 0 && cand_i[idx_c]) pick_c = idx_c;
        end
        if (pick_c >= 0) begin
            gnt_o[pick_c] = 1'b1;
            st_d.ptr = yld_i[pick_c] ? PW'((pick_c + 1) % MEMB) : PW'(pick_c);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R10
    grant_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~cand_i) == '0);

    for (genvar gm = 0; gm < MEMB; gm++) begin : g_keep_chk
        // R8
        keep_favour_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_o[gm] && !yld_i[gm]) |=> (!cand_i[gm] || gnt_o[gm]));
    end
endmodule

// File: rtl/wig_issue_gate.sv
module wig_issue_gate
    import wig_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    parameter int NUM_PARTS = 4,
    parameter int CNT_W     = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_WARPS-1:0]         req_valid,
    input  logic [NUM_WARPS*CTRL_W-1:0]  req_ctl,
    input  logic [NUM_WARPS*BAR_N-1:0]   cmpl_mask,
    output logic [NUM_WARPS-1:0]         grant,
    output logic [NUM_PARTS*REUSE_W-1:0] iss_reuse
);
    localparam int MEMB = NUM_WARPS / NUM_PARTS;

    ctl_t [NUM_WARPS-1:0]           ctl;
    logic [NUM_WARPS-1:0]           ready;
    logic [NUM_PARTS-1:0][MEMB-1:0] cand;
    logic [NUM_PARTS-1:0][MEMB-1:0] yld;
    logic [NUM_PARTS-1:0][MEMB-1:0] gnt;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        assign ctl[w] = ctl_t'(req_ctl[w*CTRL_W +: CTRL_W]);

        wig_warp_ctx #(.CNT_W(CNT_W)) ctx_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .issue_i (grant[w]),
            .stall_i (ctl[w].stall),
            .wait_i  (ctl[w].wait_mask),
            .rd_i    (ctl[w].rd_bar),
            .wr_i    (ctl[w].wr_bar),
            .cmpl_i  (cmpl_mask[w*BAR_N +: BAR_N]),
            .ready_o (ready[w])
        );
    end

    for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
        for (genvar l = 0; l < MEMB; l++) begin : g_memb
            assign cand[p][l]           = req_valid[l*NUM_PARTS+p] & ready[l*NUM_PARTS+p];
            assign yld[p][l]            = ctl[l*NUM_PARTS+p].yield_hint;
            assign grant[l*NUM_PARTS+p] = gnt[p][l];
        end

        wig_part_arb #(.MEMB(MEMB)) arb_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .cand_i (cand[p]),
            .yld_i  (yld[p]),
            .gnt_o  (gnt[p])
        );
    end

    always_comb begin
        iss_reuse = '0;
        for (int p = 0; p < NUM_PARTS; p++) begin
            for (int l = 0; l < MEMB; l++) begin
                if (gnt[p][l]) iss_reuse[p*REUSE_W +: REUSE_W] = ctl[l*NUM_PARTS+p].reuse;
            end
        end
    end

    // R10
    grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req_valid) == '0);
endmodule

// File: tb/wig_issue_gate_tb.sv
module wig_issue_gate_tb_top;
    localparam int CLK_P = 10;
    localparam int NW    = 8;
    localparam int NP    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NW-1:0]     req_valid;
    logic [NW*21-1:0]  req_ctl;
    logic [NW*6-1:0]   cmpl_mask;
    logic [NW-1:0]     grant;
    logic [NP*4-1:0]   iss_reuse;
    int                total = 0;
    int                bad = 0;

    always #(CLK_P/2) clk = ~clk;

    wig_issue_gate #(.NUM_WARPS(NW), .NUM_PARTS(NP), .CNT_W(3)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ctl   (req_ctl),
        .cmpl_mask (cmpl_mask),
        .grant     (grant),
        .iss_reuse (iss_reuse)
    );

    // R1 field packing: reuse[20:17] wait[16:11] rd[10:8] wr[7:5] yield[4] stall[3:0]
    function automatic logic [20:0] mk(input logic [3:0] ru, input logic [5:0] wt,
                                       input logic [2:0] rd, input logic [2:0] wr,
                                       input logic y, input logic [3:0] st);
        return {ru, wt, rd, wr, y, st};
    endfunction

    function automatic logic [20:0] plain();
        return mk(4'd0, 6'd0, 3'd7, 3'd7, 1'b0, 4'd0);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        req_valid = '0;
        for (int w = 0; w < NW; w++) req_ctl[w*21 +: 21] = plain();
        cmpl_mask = '0;
    endtask

    task automatic set_w(input int w, input logic [20:0] c);
        req_valid[w]      = 1'b1;
        req_ctl[w*21 +: 21] = c;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clr();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk); clr();
        #1 chk("R10 idle no grant", grant, 0);
        @(negedge clk); clr();
        for (int w = 0; w < NW; w++) set_w(w, mk(4'(w+1), 6'd0, 3'd7, 3'd7, 1'b0, 4'd0));
        #1 chk("R2/R7 lowest warp per partition", grant, 8'h0F);
        chk("R9 reuse per partition", iss_reuse, 16'h4321);
        @(negedge clk); clr();
        set_w(5, mk(4'd9, 6'd0, 3'd7, 3'd7, 1'b0, 4'd0));
        #1 chk("R8 skip idle warp", grant, 8'h20);
        chk("R9 reuse idle partitions zero", iss_reuse, 16'h0090);
    endtask

    task automatic t_stall();
        do_reset();
        @(negedge clk); clr(); set_w(0, mk(0, 0, 7, 7, 0, 4'd3));
        #1 chk("R3 first issue", grant, 8'h01);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); clr(); set_w(0, plain());
            #1 chk("R3 inside stall window", grant, 0);
        end
        @(negedge clk); clr(); set_w(0, plain());
        #1 chk("R3 window end", grant, 8'h01);
        @(negedge clk); clr(); set_w(0, plain());
        #1 chk("R3 zero stall back-to-back", grant, 8'h01);
    endtask

    task automatic t_barrier();
        do_reset();
        @(negedge clk); clr(); set_w(1, mk(0, 0, 7, 3'd2, 0, 0));
        #1 chk("R4 producer issues", grant, 8'h02);
        @(negedge clk); clr(); set_w(1, mk(0, 6'b000100, 7, 7, 0, 0));
        #1 chk("R5 consumer blocked", grant, 0);
        @(negedge clk); clr(); set_w(1, mk(0, 6'b000100, 7, 7, 0, 0));
        cmpl_mask[5*6+2] = 1'b1;
        #1 chk("R6 other warp completion", grant, 0);
        @(negedge clk); clr(); set_w(1, mk(0, 6'b000100, 7, 7, 0, 0));
        #1 chk("R6 private barrier still held", grant, 0);
        @(negedge clk); clr(); set_w(1, mk(0, 6'b000100, 7, 7, 0, 0));
        cmpl_mask[1*6+2] = 1'b1;
        #1 chk("R5 blocked in pulse cycle", grant, 0);
        @(negedge clk); clr(); set_w(1, mk(0, 6'b000100, 7, 7, 0, 0));
        #1 chk("R5 released after pulse", grant, 8'h02);
        // read and write on the same barrier count twice
        @(negedge clk); clr(); set_w(1, mk(0, 0, 3'd3, 3'd3, 0, 0));
        #1 chk("R4 double raise issue", grant, 8'h02);
        @(negedge clk); clr(); set_w(1, mk(0, 6'b001000, 7, 7, 0, 0));
        cmpl_mask[1*6+3] = 1'b1;
        #1 chk("R4 double blocked a", grant, 0);
        @(negedge clk); clr(); set_w(1, mk(0, 6'b001000, 7, 7, 0, 0));
        #1 chk("R4 double one left", grant, 0);
        @(negedge clk); clr(); set_w(1, mk(0, 6'b001000, 7, 7, 0, 0));
        cmpl_mask[1*6+3] = 1'b1;
        #1 chk("R4 double blocked b", grant, 0);
        @(negedge clk); clr(); set_w(1, mk(0, 6'b001000, 7, 7, 0, 0));
        #1 chk("R4 double released", grant, 8'h02);
        // indices 6 and 7 raise nothing
        @(negedge clk); clr(); set_w(1, mk(0, 0, 3'd6, 3'd7, 0, 0));
        #1 chk("R4 null index issue", grant, 8'h02);
        @(negedge clk); clr(); set_w(1, mk(0, 6'h3F, 7, 7, 0, 0));
        #1 chk("R4 null index sets nothing", grant, 8'h02);
    endtask

    task automatic t_sat();
        do_reset();
        for (int i = 0; i < 9; i++) begin
            @(negedge clk); clr(); set_w(2, mk(0, 0, 7, 3'd0, 0, 0));
            #1 chk("R6 fill issue", grant, 8'h04);
        end
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); clr(); set_w(2, mk(0, 6'b000001, 7, 7, 0, 0));
            cmpl_mask[2*6+0] = 1'b1;
            #1 chk("R6 saturated drain", grant, 0);
        end
        @(negedge clk); clr(); set_w(2, mk(0, 6'b000001, 7, 7, 0, 0));
        #1 chk("R6 clear after 7 pulses", grant, 8'h04);
        @(negedge clk); clr(); set_w(2, plain()); cmpl_mask[2*6+0] = 1'b1;
        #1 chk("R6 pulse on empty", grant, 8'h04);
        @(negedge clk); clr(); set_w(2, mk(0, 0, 7, 3'd0, 0, 0));
        #1 chk("R6 raise after empty pulse", grant, 8'h04);
        @(negedge clk); clr(); set_w(2, mk(0, 6'b000001, 7, 7, 0, 0));
        cmpl_mask[2*6+0] = 1'b1;
        #1 chk("R6 single count held", grant, 0);
        @(negedge clk); clr(); set_w(2, mk(0, 6'b000001, 7, 7, 0, 0));
        #1 chk("R6 no underflow", grant, 8'h04);
    endtask

    task automatic t_rr();
        do_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); clr(); set_w(0, plain()); set_w(4, plain());
            #1 chk("R8 keep favoured warp", grant, 8'h01);
        end
        @(negedge clk); clr(); set_w(0, mk(0, 0, 7, 7, 1'b1, 0)); set_w(4, plain());
        #1 chk("R8 yield issue", grant, 8'h01);
        @(negedge clk); clr(); set_w(0, plain()); set_w(4, plain());
        #1 chk("R8 rotated after yield", grant, 8'h10);
        @(negedge clk); clr(); set_w(0, plain()); set_w(4, mk(0, 0, 7, 7, 1'b1, 0));
        #1 chk("R8 new warp kept", grant, 8'h10);
        @(negedge clk); clr(); set_w(0, mk(0, 0, 7, 7, 0, 4'd2)); set_w(4, plain());
        #1 chk("R8 back after second yield", grant, 8'h01);
        @(negedge clk); clr(); set_w(0, plain()); set_w(4, plain());
        #1 chk("R8 skip stalled warp", grant, 8'h10);
        @(negedge clk); clr(); set_w(0, plain()); set_w(4, plain());
        #1 chk("R8 pointer on skipped-to warp", grant, 8'h10);
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++;
        total++;
        $display("FAIL R10 watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clr();
        t_reset();
        t_stall();
        t_barrier();
        t_sat();
        t_rr();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule